// File: doc/BRIEF.md
# Reset press-duration classifier

This block watches an active-low reset pushbutton and sorts each clean press by how long it was held. It sends the raw line through a two-flop synchronizer and a filter that reacts to both edges. It then times the filtered press in ticks of a slow oscillator. Every release sets an override of the static protect switch for one cartridge memory window. A short press clears the override to "writable". A long or extended press sets it to "protected". An extended press also disables the window for a fixed holdoff time after release. During that time the window cannot be seen at all, so boot code that probes it skips it.

The block also gates the window's chip select. Reads are blocked while the window is disabled. Writes are blocked while it is disabled or protected. An indicator LED is lit while the window is protected or disabled. All thresholds are parameters counted in oscillator ticks. The defaults assume a 6.25 kHz tick: about 50 ms of filtering, a long press from 0.5 s and an extended press from 1 s. Until the first release after power-on, the protect flag follows the switch input.

The press timer is a state machine with five states:
- IDLE: released, no holdoff running.
- HELD_SHORT: held for fewer than LONG_TICKS ticks.
- HELD_LONG: held for at least LONG_TICKS ticks.
- HELD_EXT: held for at least EXT_TICKS ticks.
- HOLDOFF: released after an extended press; the disable is active.

Transitions:
- IDLE to HELD_SHORT on press.
- HELD_SHORT to IDLE on release, which captures "writable".
- HELD_SHORT to HELD_LONG at the long threshold.
- HELD_LONG to IDLE on release, which captures "protected".
- HELD_LONG to HELD_EXT at the extended threshold.
- HELD_EXT to HOLDOFF on release, which captures "protected".
- HOLDOFF to IDLE after EXT_TICKS ticks.
- HOLDOFF to HELD_SHORT on a new press, which ends the disable.

Top module: `reset_press_classifier`

## Requirements
- R1: A change of the raw button level that lasts fewer than DG_TICKS ticks has no effect on the filtered line. It therefore changes neither the protect flag nor the disable.
- R2: The filtered release of a press held fewer than LONG_TICKS ticks sets the protect flag to 0, whatever the switch input is.
- R3: The filtered release of a press held at least LONG_TICKS ticks but fewer than EXT_TICKS ticks sets the protect flag to 1 and leaves the disable at 0.
- R4: The filtered release of a press held at least EXT_TICKS ticks sets the protect flag to 1. It also asserts the disable, which stays asserted for EXT_TICKS ticks and then drops.
- R5: From power-on reset until the first filtered release, the protect flag equals the sw_protect input.
- R6: While the disable is asserted, win_cs is 0 for every access.
- R7: While the protect flag is 1, win_cs is 0 when wr_en is 1. A read (wr_en = 0) with win_sel = 1 still gives win_cs = 1. When neither the disable nor the protect flag is set, win_cs equals win_sel.
- R8: led equals protect OR disable.
- R9: Power-on reset clears any captured override and any disable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| tick | input | 1 | One-cycle enable from the slow oscillator divider |
| btn_raw_n | input | 1 | Raw reset button line, low while pressed |
| sw_protect | input | 1 | Static protect switch, 1 = protected |
| win_sel | input | 1 | Decoded select of the memory window |
| wr_en | input | 1 | Memory write strobe, 1 = write access |
| win_cs | output | 1 | Gated chip select of the window |
| protect | output | 1 | Current write-protect state |
| win_disable | output | 1 | Temporary disable of the window |
| led | output | 1 | Indicator LED drive, 1 = lit |

## Verification
The assertions assume that tick is a one-cycle pulse that the sampling logic sees in step with clk. They also assume the button line settles between ticks, so the filter sees one level per tick. The bench raises tick on every second clock and holds every raw level for a whole number of tick periods. It uses shortened thresholds. Each press length is kept several ticks away from every threshold, so the class is not affected by the two synchronizer stages or the filter delay.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_HELD_SHORT = 3'd1,
        ST_HELD_LONG  = 3'd2,
        ST_HELD_EXT   = 3'd3,
        ST_HOLDOFF    = 3'd4
    } press_state_t;
endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rpc_deglitch.sv
module rpc_deglitch #(
    parameter int DG_TICKS = 312
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic level_in,
    output logic level_out
);
    localparam int W = $clog2(DG_TICKS + 1);
    localparam logic [W-1:0] LAST = W'(DG_TICKS - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt       <= '0;
            level_out <= 1'b1;
        end else if (level_in == level_out) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) begin
                level_out <= level_in;
                cnt       <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R1: the filtered level may only move on a tick
    a_r1_moves_on_tick: assert property (@(posedge clk) disable iff (!por_n)
        (level_out != $past(level_out)) |-> $past(tick));
endmodule

// File: rtl/rpc_press_fsm.sv
module rpc_press_fsm
    import rpc_pkg::*;
#(
    parameter int LONG_TICKS = 3125,
    parameter int EXT_TICKS  = 6250
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic btn_n,
    output logic ovr_valid,
    output logic ovr_prot,
    output logic dis
);
    localparam int CW = $clog2(EXT_TICKS + 1);
    localparam logic [CW-1:0] LONG_LAST = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] EXT_LAST  = CW'(EXT_TICKS - 1);

    press_state_t state, state_nx;
    logic [CW-1:0] cnt;
    logic          long_hit, ext_hit;

    assign long_hit = tick && (cnt == LONG_LAST);
    assign ext_hit  = tick && (cnt == EXT_LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (!btn_n)       state_nx = ST_HELD_SHORT;
            ST_HELD_SHORT: if (btn_n)        state_nx = ST_IDLE;
                           else if (long_hit) state_nx = ST_HELD_LONG;
            ST_HELD_LONG:  if (btn_n)        state_nx = ST_IDLE;
                           else if (ext_hit) state_nx = ST_HELD_EXT;
            ST_HELD_EXT:   if (btn_n)        state_nx = ST_HOLDOFF;
            ST_HOLDOFF:    if (!btn_n)       state_nx = ST_HELD_SHORT;
                           else if (ext_hit) state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (state_nx != state) begin
            cnt <= (state_nx == ST_HELD_SHORT || state_nx == ST_HOLDOFF) ? '0 : cnt;
        end else if (tick && state != ST_IDLE && state != ST_HELD_EXT) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ovr_valid <= 1'b0;
            ovr_prot  <= 1'b0;
        end else if (btn_n && (state == ST_HELD_SHORT || state == ST_HELD_LONG ||
                               state == ST_HELD_EXT)) begin
            ovr_valid <= 1'b1;
            ovr_prot  <= (state != ST_HELD_SHORT);
        end
    end

    always_comb begin
        dis = 1'b0;
        unique case (state)
            ST_HOLDOFF: dis = 1'b1;
            default:    dis = 1'b0;
        endcase
    end

    // R2: a release from a short hold captures writable
    a_r2_short_clears: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_HELD_SHORT && btn_n) |=> (ovr_valid && !ovr_prot));
    // R3: a release from a long hold captures protected, no disable
    a_r3_long_protects: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_HELD_LONG && btn_n) |=> (ovr_valid && ovr_prot && !dis));
    // R4: the disable only starts after an extended hold
    a_r4_disable_after_ext: assert property (@(posedge clk) disable iff (!por_n)
        $rose(dis) |-> ($past(state) == ST_HELD_EXT));
endmodule

// File: rtl/reset_press_classifier.sv
module reset_press_classifier #(
    parameter int DG_TICKS   = 312,
    parameter int LONG_TICKS = 3125,
    parameter int EXT_TICKS  = 6250
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic btn_raw_n,
    input  logic sw_protect,
    input  logic win_sel,
    input  logic wr_en,
    output logic win_cs,
    output logic protect,
    output logic win_disable,
    output logic led
);
    logic btn_sync_n, btn_clean_n, ovr_valid, ovr_prot;

    rpc_sync #(.STAGES(2)) u_sync (
        .clk(clk), .por_n(por_n), .d_in(btn_raw_n), .d_out(btn_sync_n)
    );

    rpc_deglitch #(.DG_TICKS(DG_TICKS)) u_filt (
        .clk(clk), .por_n(por_n), .tick(tick),
        .level_in(btn_sync_n), .level_out(btn_clean_n)
    );

    rpc_press_fsm #(.LONG_TICKS(LONG_TICKS), .EXT_TICKS(EXT_TICKS)) u_fsm (
        .clk(clk), .por_n(por_n), .tick(tick), .btn_n(btn_clean_n),
        .ovr_valid(ovr_valid), .ovr_prot(ovr_prot), .dis(win_disable)
    );

    assign protect = ovr_valid ? ovr_prot : sw_protect;
    assign win_cs  = win_sel && !win_disable && !(protect && wr_en);
    assign led     = protect || win_disable;

    // R6: a disabled window never sees a select
    a_r6_disable_blocks: assert property (@(posedge clk) disable iff (!por_n)
        win_disable |-> !win_cs);
    // R7: writes into a protected window are blocked
    a_r7_write_blocked: assert property (@(posedge clk) disable iff (!por_n)
        (protect && wr_en) |-> !win_cs);
endmodule

// File: tb/test_reset_press_classifier.sv
module test_reset_press_classifier;
    localparam int DG = 4, LNG = 20, EXT = 40;

    logic clk = 0, por_n = 0, tick = 0, btn_raw_n = 1;
    logic sw_protect = 0, win_sel = 0, wr_en = 0;
    logic win_cs, protect, win_disable, led;
    int n_chk = 0, n_bad = 0;

    reset_press_classifier #(.DG_TICKS(DG), .LONG_TICKS(LNG), .EXT_TICKS(EXT))
    i_reset_press_classifier (
        .clk(clk), .por_n(por_n), .tick(tick), .btn_raw_n(btn_raw_n),
        .sw_protect(sw_protect), .win_sel(win_sel), .wr_en(wr_en),
        .win_cs(win_cs), .protect(protect), .win_disable(win_disable), .led(led)
    );

    always #10 clk = ~clk;
    initial forever begin @(negedge clk); tick = ~tick; end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cs_chk(input string req, input logic sel, input logic wr, input logic exp);
        win_sel = sel; wr_en = wr; #1;
        chk(req, win_cs, exp);
        win_sel = 0; wr_en = 0;
    endtask

    task automatic hold(input int ticks);
        btn_raw_n = 0; cyc(2 * ticks);
        btn_raw_n = 1; cyc(30);
    endtask

    task automatic t_reset;
        chk("R5 protect=sw at reset", protect, 1'b0);
        chk("R9 disable clear", win_disable, 1'b0);
        chk("R8 led off", led, 1'b0);
        cs_chk("R7 write passes", 1, 1, 1'b1);
        sw_protect = 1; #1;
        chk("R5 protect follows sw", protect, 1'b1);
        chk("R8 led on", led, 1'b1);
        cs_chk("R7 write blocked", 1, 1, 1'b0);
        cs_chk("R7 read passes", 1, 0, 1'b1);
    endtask

    task automatic t_glitch;
        btn_raw_n = 0; cyc(4); btn_raw_n = 1; cyc(30);
        chk("R1 glitch ignored, protect", protect, 1'b1);
        chk("R1 glitch ignored, disable", win_disable, 1'b0);
    endtask

    task automatic t_short;
        hold(10);
        chk("R2 short clears protect", protect, 1'b0);
        chk("R2 no disable", win_disable, 1'b0);
        cs_chk("R7 write passes after short", 1, 1, 1'b1);
    endtask

    task automatic t_long;
        sw_protect = 0;
        hold(30);
        chk("R3 long protects", protect, 1'b1);
        chk("R3 no disable", win_disable, 1'b0);
        cs_chk("R7 read passes when protected", 1, 0, 1'b1);
    endtask

    task automatic t_ext;
        hold(60);
        chk("R4 ext protects", protect, 1'b1);
        chk("R4 disable asserted", win_disable, 1'b1);
        chk("R8 led during disable", led, 1'b1);
        cs_chk("R6 read blocked", 1, 0, 1'b0);
        cyc(100);
        chk("R4 disable ended", win_disable, 1'b0);
        cs_chk("R6 read restored", 1, 0, 1'b1);
    endtask

    task automatic t_short_again;
        hold(10);
        chk("R2 short after ext", protect, 1'b0);
        chk("R8 led off again", led, 1'b0);
    endtask

    task automatic t_por;
        hold(30);
        sw_protect = 0;
        por_n = 0; cyc(2); por_n = 1; cyc(2);
        chk("R9 por clears override", protect, 1'b0);
        sw_protect = 1; #1;
        chk("R9 sw in control after por", protect, 1'b1);
    endtask

    initial begin
        cyc(3); por_n = 1; cyc(2);
        t_reset();
        t_glitch();
        t_short();
        t_long();
        t_ext();
        t_short_again();
        t_por();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule